// File: doc/BRIEF.md
# Transport Stream Input Front End

This block sits at the edge of a transport stream demultiplexer. It takes a stream from an error-correction device, either a whole byte per input clock or one bit per input clock, depending on a static mode pin. It turns that stream into bytes, marks the byte that opens each 188-byte packet, and flags bytes that belong to a packet the upstream device reported as damaged. The input clock does not need any fixed relation to the core clock. A 16-entry gray-pointer asynchronous FIFO carries each tagged byte into the core domain.

In serial mode, bits arrive most significant first on bit 0 of the data bus. An alignment strobe marks the first bit of a byte. The upstream device may raise it on every byte or only on sync bytes. A packet-start detector searches for the sync value 0x47 while it is unlocked. Once locked, it expects the next sync exactly one packet length later, and it falls back to searching when that byte is wrong. The error input is active low. It replaces the error bit in the packet header, and the block keeps its state sticky over the rest of the packet. The core side pulls the FIFO on every core clock in which it holds data, so the core consumer sees one byte per `out_valid_o` pulse.

Top module: `ts_input_frontend`

## Requirements
- R1: While `rst_ni` is low, and afterwards until the first byte has crossed, `out_valid_o` and `ovf_o` are 0.
- R2: With `serial_mode_i` = 0, every rising edge of `in_clk_i` with `in_valid_i` = 1 captures `in_data_i` as one byte. Bytes reach `out_byte_o` in capture order. Every parallel byte counts as aligned, and `in_align_i` has no effect.
- R3: With `serial_mode_i` = 1, each valid cycle shifts in `in_data_i[0]`, most significant bit first. A byte is complete after 8 valid bits. An `in_align_i` = 1 on a valid bit restarts assembly with that bit and drops any partial byte. Bits that arrive before the first aligned bit produce nothing.
- R4: Cycles with `in_valid_i` = 0 are ignored entirely: data, alignment strobe and error input have no effect on the output stream.
- R5: `out_sop_o` = 1 only on a byte equal to 0x47 that is aligned (in serial mode, its first bit carried `in_align_i` = 1). Such a byte is a packet start when no packet is locked, or when it arrives exactly 188 bytes after the previous packet start.
- R6: While locked, a 0x47 byte at any other position is not a start. If the byte 188 positions after a start is not an aligned 0x47, lock is lost and any later aligned 0x47 is taken as a start.
- R7: `out_err_o` = 1 if `in_err_ni` was 0 on any valid cycle of this byte, or if it was 1 on an earlier byte since the last packet start. A start byte carries only its own error state.
- R8: The FIFO holds 16 bytes. A byte that arrives while it is full is dropped and sets `ovf_o`, which stays 1 until reset. Without overflow, every byte is delivered exactly once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| in_clk_i | input | 1 | Input stream clock, asynchronous to clk_i |
| clk_i | input | 1 | Core clock |
| rst_ni | input | 1 | Asynchronous active-low reset for both domains |
| serial_mode_i | input | 1 | 0 = byte-parallel, 1 = bit-serial; static outside reset |
| in_data_i | input | 8 | Input byte, or serial bit on bit 0 |
| in_valid_i | input | 1 | Input qualifier, sampled on in_clk_i |
| in_align_i | input | 1 | Serial mode: first bit of a byte |
| in_err_ni | input | 1 | Active-low packet error from upstream |
| out_valid_o | output | 1 | One-cycle strobe per delivered byte (clk_i domain) |
| out_byte_o | output | 8 | Delivered byte |
| out_sop_o | output | 1 | Byte is a packet start |
| out_err_o | output | 1 | Byte belongs to an erroneous packet |
| ovf_o | output | 1 | Sticky FIFO overflow (in_clk_i domain) |

## Verification
The assertions assume that `serial_mode_i` changes only while reset is held. The sticky-error relation across delivered bytes also assumes that no byte has been dropped; that check is disabled once `ovf_o` is high. The stimulus switches mode only inside a reset sequence. It runs the input clock slower than the core clock in every phase except a single overflow burst, and that burst is followed by a fresh reset. Idle cycles carry random data, alignment and error values, so the bench shows that they are ignored.

// File: rtl/ts_fe_pkg.sv
package ts_fe_pkg;

  localparam int unsigned BYTE_W = 8;

  typedef struct packed {
    logic [BYTE_W-1:0] data;
    logic              sop;
    logic              err;
  } ts_byte_t;

  typedef enum logic {
    MODE_PAR = 1'b0,
    MODE_SER = 1'b1
  } in_mode_e;

  function automatic logic [4:0] bin2gray5(input logic [4:0] b);
    return b ^ (b >> 1);
  endfunction

endpackage

// File: rtl/ts_fe_sync.sv
module ts_fe_sync #(
  parameter int unsigned W = 1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);

  logic [W-1:0] meta_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      meta_q <= '0;
      q_o    <= '0;
    end else begin
      meta_q <= d_i;
      q_o    <= meta_q;
    end
  end

endmodule

// File: rtl/ts_fe_deser.sv
module ts_fe_deser
  import ts_fe_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              serial_i,
  input  logic [BYTE_W-1:0] data_i,
  input  logic              valid_i,
  input  logic              align_i,
  input  logic              err_ni,
  output logic              byte_vld_o,
  output logic [BYTE_W-1:0] byte_o,
  output logic              aligned_o,
  output logic              byte_err_o
);

  localparam int unsigned CW = $clog2(BYTE_W);

  logic [BYTE_W-1:0] sr_q, sr_nxt;
  logic [CW-1:0]     bit_cnt_q, cnt_now;
  logic              have_align_q;
  logic              acc_err_q, acc_aln_q;
  logic              take, err_nxt, aln_nxt, last_bit;

  always_comb begin
    take     = valid_i && serial_i && (align_i || have_align_q);
    cnt_now  = align_i ? '0 : bit_cnt_q;
    sr_nxt   = {sr_q[BYTE_W-2:0], data_i[0]};
    err_nxt  = (align_i ? 1'b0 : acc_err_q) | ~err_ni;
    aln_nxt  = align_i | acc_aln_q;
    last_bit = (cnt_now == CW'(BYTE_W - 1));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sr_q         <= '0;
      bit_cnt_q    <= '0;
      have_align_q <= 1'b0;
      acc_err_q    <= 1'b0;
      acc_aln_q    <= 1'b0;
      byte_vld_o   <= 1'b0;
      byte_o       <= '0;
      aligned_o    <= 1'b0;
      byte_err_o   <= 1'b0;
    end else begin
      byte_vld_o <= 1'b0;
      if (valid_i && !serial_i) begin
        byte_vld_o <= 1'b1;
        byte_o     <= data_i;
        aligned_o  <= 1'b1;
        byte_err_o <= ~err_ni;
      end else if (take) begin
        have_align_q <= 1'b1;
        sr_q         <= sr_nxt;
        if (last_bit) begin
          byte_vld_o <= 1'b1;
          byte_o     <= sr_nxt;
          aligned_o  <= aln_nxt;
          byte_err_o <= err_nxt;
          bit_cnt_q  <= '0;
          acc_err_q  <= 1'b0;
          acc_aln_q  <= 1'b0;
        end else begin
          bit_cnt_q <= cnt_now + 1'b1;
          acc_err_q <= err_nxt;
          acc_aln_q <= aln_nxt;
        end
      end
    end
  end

endmodule

// File: rtl/ts_fe_framer.sv
module ts_fe_framer
  import ts_fe_pkg::*;
#(
  parameter int unsigned       PKT_LEN   = 188,
  parameter logic [BYTE_W-1:0] SYNC_BYTE = 8'h47
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              byte_vld_i,
  input  logic [BYTE_W-1:0] byte_i,
  input  logic              aligned_i,
  input  logic              byte_err_i,
  output logic              wr_o,
  output ts_byte_t          wdata_o
);

  localparam int unsigned CNT_W = $clog2(PKT_LEN + 1);

  logic [CNT_W-1:0] cnt_q;
  logic             locked_q, pkt_err_q;
  logic             at_slot, sop, err;

  always_comb begin
    at_slot = (cnt_q == CNT_W'(PKT_LEN));
    sop     = (byte_i == SYNC_BYTE) && aligned_i && (!locked_q || at_slot);
    err     = byte_err_i | (~sop & pkt_err_q);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q     <= '0;
      locked_q  <= 1'b0;
      pkt_err_q <= 1'b0;
      wr_o      <= 1'b0;
      wdata_o   <= '0;
    end else begin
      wr_o <= byte_vld_i;
      if (byte_vld_i) begin
        wdata_o   <= '{data: byte_i, sop: sop, err: err};
        pkt_err_q <= err;
        if (sop) begin
          locked_q <= 1'b1;
          cnt_q    <= CNT_W'(1);
        end else if (locked_q) begin
          if (at_slot) locked_q <= 1'b0;
          else         cnt_q    <= cnt_q + 1'b1;
        end
      end
    end
  end

endmodule

// File: rtl/ts_fe_afifo.sv
module ts_fe_afifo
  import ts_fe_pkg::*;
#(
  parameter int unsigned W  = 10,
  parameter int unsigned AW = 4
) (
  input  logic         wclk_i,
  input  logic         rclk_i,
  input  logic         rst_ni,
  input  logic         wr_i,
  input  logic [W-1:0] wdata_i,
  output logic         ovf_o,
  output logic         rvalid_o,
  output logic [W-1:0] rdata_o
);

  localparam int unsigned PW    = AW + 1;
  localparam int unsigned DEPTH = 1 << AW;

  logic [W-1:0]  mem [DEPTH];
  logic [PW-1:0] wbin_q, wgray_q, rbin_q, rgray_q;
  logic [PW-1:0] rgray_w, wgray_r;
  logic [PW-1:0] wbin_inc, rbin_inc;
  logic          full, empty;

  function automatic logic [PW-1:0] to_gray(input logic [PW-1:0] b);
    return b ^ (b >> 1);
  endfunction

  ts_fe_sync #(.W(PW)) i_sync_r2w (
    .clk_i (wclk_i), .rst_ni (rst_ni), .d_i (rgray_q), .q_o (rgray_w)
  );

  ts_fe_sync #(.W(PW)) i_sync_w2r (
    .clk_i (rclk_i), .rst_ni (rst_ni), .d_i (wgray_q), .q_o (wgray_r)
  );

  assign wbin_inc = wbin_q + 1'b1;
  assign rbin_inc = rbin_q + 1'b1;
  assign full     = (wgray_q == {~rgray_w[PW-1:PW-2], rgray_w[PW-3:0]});
  assign empty    = (rgray_q == wgray_r);

  always_ff @(posedge wclk_i) begin
    if (wr_i && !full) mem[wbin_q[AW-1:0]] <= wdata_i;
  end

  always_ff @(posedge wclk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wbin_q  <= '0;
      wgray_q <= '0;
      ovf_o   <= 1'b0;
    end else if (wr_i) begin
      if (full) begin
        ovf_o <= 1'b1;
      end else begin
        wbin_q  <= wbin_inc;
        wgray_q <= to_gray(wbin_inc);
      end
    end
  end

  always_ff @(posedge rclk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rbin_q   <= '0;
      rgray_q  <= '0;
      rvalid_o <= 1'b0;
      rdata_o  <= '0;
    end else begin
      rvalid_o <= !empty;
      if (!empty) begin
        rdata_o <= mem[rbin_q[AW-1:0]];
        rbin_q  <= rbin_inc;
        rgray_q <= to_gray(rbin_inc);
      end
    end
  end

endmodule

// File: rtl/ts_input_frontend.sv
module ts_input_frontend
  import ts_fe_pkg::*;
#(
  parameter int unsigned       PKT_LEN   = 188,
  parameter logic [BYTE_W-1:0] SYNC_BYTE = 8'h47,
  parameter int unsigned       FIFO_AW   = 4
) (
  input  logic              in_clk_i,
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              serial_mode_i,
  input  logic [BYTE_W-1:0] in_data_i,
  input  logic              in_valid_i,
  input  logic              in_align_i,
  input  logic              in_err_ni,
  output logic              out_valid_o,
  output logic [BYTE_W-1:0] out_byte_o,
  output logic              out_sop_o,
  output logic              out_err_o,
  output logic              ovf_o
);

  localparam int unsigned TW = $bits(ts_byte_t);

  logic              byte_vld, aligned, byte_err, wr;
  logic [BYTE_W-1:0] byte_d;
  ts_byte_t          wdata, rdata;
  logic [TW-1:0]     rdata_raw;
  in_mode_e          mode;

  assign mode = in_mode_e'(serial_mode_i);

  ts_fe_deser i_deser (
    .clk_i      (in_clk_i),
    .rst_ni     (rst_ni),
    .serial_i   (mode == MODE_SER),
    .data_i     (in_data_i),
    .valid_i    (in_valid_i),
    .align_i    (in_align_i),
    .err_ni     (in_err_ni),
    .byte_vld_o (byte_vld),
    .byte_o     (byte_d),
    .aligned_o  (aligned),
    .byte_err_o (byte_err)
  );

  ts_fe_framer #(.PKT_LEN(PKT_LEN), .SYNC_BYTE(SYNC_BYTE)) i_framer (
    .clk_i      (in_clk_i),
    .rst_ni     (rst_ni),
    .byte_vld_i (byte_vld),
    .byte_i     (byte_d),
    .aligned_i  (aligned),
    .byte_err_i (byte_err),
    .wr_o       (wr),
    .wdata_o    (wdata)
  );

  ts_fe_afifo #(.W(TW), .AW(FIFO_AW)) i_fifo (
    .wclk_i   (in_clk_i),
    .rclk_i   (clk_i),
    .rst_ni   (rst_ni),
    .wr_i     (wr),
    .wdata_i  (wdata),
    .ovf_o    (ovf_o),
    .rvalid_o (out_valid_o),
    .rdata_o  (rdata_raw)
  );

  assign rdata      = ts_byte_t'(rdata_raw);
  assign out_byte_o = rdata.data;
  assign out_sop_o  = rdata.sop;
  assign out_err_o  = rdata.err;

endmodule

// File: rtl/ts_fe_checks.sv
module ts_fe_checks #(
  parameter logic [7:0] SYNC_BYTE = 8'h47
) (
  input logic       in_clk_i,
  input logic       clk_i,
  input logic       rst_ni,
  input logic       serial_mode_i,
  input logic       in_valid_i,
  input logic       byte_vld,
  input logic       out_valid_o,
  input logic [7:0] out_byte_o,
  input logic       out_sop_o,
  input logic       out_err_o,
  input logic       ovf_o
);

  logic last_err_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          last_err_q <= 1'b0;
    else if (out_valid_o) last_err_q <= out_err_o;
  end

  AST_PAR_CAPTURE: assert property (@(posedge in_clk_i) disable iff (!rst_ni)
    (!serial_mode_i && in_valid_i) |=> byte_vld); // R2

  AST_IDLE_IGNORED: assert property (@(posedge in_clk_i) disable iff (!rst_ni)
    !in_valid_i |=> !byte_vld); // R4

  AST_SOP_IS_SYNC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o && out_sop_o) |-> (out_byte_o == SYNC_BYTE)); // R5

  AST_ERR_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni || ovf_o)
    (out_valid_o && !out_sop_o && last_err_q) |-> out_err_o); // R7

  AST_OVF_STICKY: assert property (@(posedge in_clk_i) disable iff (!rst_ni)
    ovf_o |=> ovf_o); // R8

endmodule

bind ts_input_frontend ts_fe_checks #(.SYNC_BYTE(SYNC_BYTE)) i_checks (
  .in_clk_i      (in_clk_i),
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .serial_mode_i (serial_mode_i),
  .in_valid_i    (in_valid_i),
  .byte_vld      (byte_vld),
  .out_valid_o   (out_valid_o),
  .out_byte_o    (out_byte_o),
  .out_sop_o     (out_sop_o),
  .out_err_o     (out_err_o),
  .ovf_o         (ovf_o)
);

// File: tb/test_ts_input_frontend.sv
module test_ts_input_frontend;

  localparam int PKT = 188;

  logic clk = 0, in_clk = 0, rst_n = 0;
  logic serial_mode = 0, in_valid = 0, in_align = 0, in_err_n = 1;
  logic [7:0] in_data = '0;
  logic out_valid, out_sop, out_err, ovf;
  logic [7:0] out_byte;
  int in_half = 6;

  int n_checks = 0, n_fail = 0;
  logic [9:0] exp_q[$];
  bit cmp_en = 1;
  int rx_cnt = 0;
  string cur_req = "R2";

  bit m_locked; int m_cnt; bit m_pkt_err; bit s_have_align;

  always #2.5 clk = ~clk;
  always #(in_half) in_clk = ~in_clk;

  ts_input_frontend i_ts_input_frontend (
    .in_clk_i(in_clk), .clk_i(clk), .rst_ni(rst_n), .serial_mode_i(serial_mode),
    .in_data_i(in_data), .in_valid_i(in_valid), .in_align_i(in_align), .in_err_ni(in_err_n),
    .out_valid_o(out_valid), .out_byte_o(out_byte), .out_sop_o(out_sop),
    .out_err_o(out_err), .ovf_o(ovf)
  );

  task automatic check(input bit ok, input string req, input string what, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // reference model of R5, R6, R7
  function automatic void model_push(input logic [7:0] d, input bit aligned, input bit berr);
    bit sop, err;
    sop = (d == 8'h47) && aligned && (!m_locked || m_cnt == PKT);
    err = berr | (!sop && m_pkt_err);
    exp_q.push_back({d, sop, err});
    m_pkt_err = err;
    if (sop) begin m_locked = 1; m_cnt = 1; end
    else if (m_locked) begin
      if (m_cnt == PKT) m_locked = 0; else m_cnt++;
    end
  endfunction

  always @(negedge clk) begin
    if (rst_n && out_valid) begin
      rx_cnt++;
      if (cmp_en) begin
        if (exp_q.size() == 0) check(0, cur_req, "unexpected byte", out_byte, 0);
        else begin
          logic [9:0] e;
          e = exp_q.pop_front();
          check(out_byte == e[9:2], cur_req, "byte", out_byte, e[9:2]);
          check(out_sop == e[1], "R5", "sop", out_sop, e[1]);
          check(out_err == e[0], "R7", "err", out_err, e[0]);
        end
      end
    end
  end

  task automatic junk();  // R4: idle cycle with random content
    @(negedge in_clk);
    in_valid = 0; in_data = 8'($urandom); in_align = 1'($urandom); in_err_n = 1'($urandom);
  endtask

  task automatic do_reset(input bit mode);
    rst_n = 0; in_valid = 0;
    serial_mode = mode;
    repeat (4) @(negedge in_clk);
    repeat (4) @(negedge clk);
    check(out_valid == 0, "R1", "out_valid in reset", out_valid, 0);
    check(ovf == 0, "R1", "ovf in reset", ovf, 0);
    exp_q.delete();
    m_locked = 0; m_cnt = 0; m_pkt_err = 0; s_have_align = 0;
    @(negedge clk); rst_n = 1;
    repeat (3) @(negedge clk);
    check(out_valid == 0, "R1", "out_valid after reset", out_valid, 0);
  endtask

  task automatic par_byte(input logic [7:0] d, input bit e, input bit gaps);
    if (gaps && ($urandom % 4 == 0)) junk();
    @(negedge in_clk);
    in_valid = 1; in_data = d; in_align = 1'($urandom); in_err_n = !e;
    if (cmp_en) model_push(d, 1, e);
  endtask

  task automatic ser_byte(input logic [7:0] d, input bit aln, input bit e);
    int ebit = $urandom % 8;
    for (int i = 7; i >= 0; i--) begin
      if ($urandom % 5 == 0) junk();
      @(negedge in_clk);
      in_valid = 1; in_data = {7'($urandom), d[i]};
      in_align = aln && (i == 7);
      in_err_n = !(e && i == ebit);
    end
    if (aln) s_have_align = 1;
    if (s_have_align) model_push(d, aln, e);
  endtask

  task automatic ser_partial(input int n);  // R3: dropped by the next aligned bit
    for (int i = 0; i < n; i++) begin
      @(negedge in_clk);
      in_valid = 1; in_data = 8'($urandom); in_align = 0; in_err_n = 0;
    end
  endtask

  function automatic logic [7:0] pay();
    logic [7:0] b = 8'($urandom);
    if ($urandom % 12 == 0) b = 8'h47;
    return b;
  endfunction

  task automatic send_pkt(input bit ser, input bit good, input bit aln_all);
    logic [7:0] s = good ? 8'h47 : 8'h48;
    if (ser) ser_byte(s, 1, ($urandom % 40 == 0));
    else     par_byte(s, ($urandom % 40 == 0), 1);
    for (int i = 1; i < PKT; i++) begin
      if (ser) ser_byte(pay(), aln_all, ($urandom % 60 == 0));
      else     par_byte(pay(), ($urandom % 60 == 0), 1);
    end
  endtask

  task automatic drain(input string req);
    @(negedge in_clk); in_valid = 0;
    repeat (80) @(negedge clk);
    check(exp_q.size() == 0, req, "bytes missing after drain", exp_q.size(), 0);
  endtask

  initial begin
    void'($urandom(32'h5EED1234));
    // R1
    do_reset(0);

    // R2, R4, R5, R7: parallel mode, lock and errors
    cur_req = "R2";
    for (int p = 0; p < 3; p++) send_pkt(0, 1, 1);
    // R6: wrong sync drops lock, search resumes
    cur_req = "R6";
    send_pkt(0, 0, 1);
    for (int p = 0; p < 2; p++) send_pkt(0, 1, 1);
    drain("R2");
    check(ovf == 0, "R8", "no overflow at low rate", ovf, 0);

    // R3: serial mode
    cur_req = "R3";
    do_reset(1);
    ser_byte(8'h47, 0, 0);              // before first alignment: discarded
    ser_byte(8'h12, 0, 0);
    drain("R3");
    for (int p = 0; p < 2; p++) send_pkt(1, 1, 1);
    for (int p = 0; p < 2; p++) send_pkt(1, 1, 0);
    ser_partial(3);
    ser_byte(8'hA5, 1, 1);
    ser_byte(8'h47, 1, 0);
    drain("R3");

    // R8: overflow burst
    cur_req = "R8";
    do_reset(0);
    cmp_en = 0; rx_cnt = 0;
    in_half = 1;
    @(negedge in_clk); @(negedge in_clk);
    for (int i = 0; i < 150; i++) par_byte(8'(i), 0, 0);
    @(negedge in_clk); in_valid = 0;
    repeat (100) @(negedge clk);
    check(ovf == 1, "R8", "ovf after burst", ovf, 1);
    check(rx_cnt < 150 && rx_cnt >= 16, "R8", "bytes delivered", rx_cnt, 150);
    in_half = 6;
    do_reset(0);
    check(ovf == 0, "R8", "ovf cleared by reset", ovf, 0);

    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end

  initial begin
    #900us;
    n_checks++; n_fail++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end

endmodule